// File: doc/BRIEF.md
# Timer with Assignable Prescaler

This block is an 8-bit up-counter for timing and event counting. Its count source is either a per-instruction-cycle enable (`cyc_tick`) or edges seen on an external pin. An 8-bit free-running prescaler sits in front of the counter. A 3-bit rate code picks one of its taps, so the counter advances once every 2, 4, ... 256 source events. A single assignment bit can hand the prescaler over to a watchdog-side path instead. In that case the counter advances on every source event, and the prescaler produces a watchdog tick from the instruction-cycle enable.

Software uses a small register bus with three locations:

- the counter value,
- an 8-bit configuration register,
- a sticky wrap flag.

The flag sets whenever the counter rolls from 255 to 0, and software clears it. Writing the counter clears the prescaler, so a delay that starts with a write always gets full prescaled periods. Loading 256−N produces a wrap after N further increments.

Top module: `tick_timer`

## Requirements
- R1: After reset, the counter reads 0x00, the configuration reads 0xFF and the flag reads 0.
- R2: Registers are addressed as follows. Address 0 is the counter, address 1 is the configuration and address 2 is the flag (bit 0). A write to address 0 or 1 stores the data, and `rdata` returns the new value in the cycle after the write.
- R3: The configuration fields are rate = bits 2:0, edge select = bit 3, assignment = bit 4 and source = bit 5. With assignment=1 and source=0, the counter adds 1 in every cycle with `cyc_tick` high, and 255 is followed by 0.
- R4: With assignment=0, rate code k divides the source events by 2^(k+1). After a counter write, the first increment comes on the 2^(k+1)-th source event (code 0 = 1:2, code 7 = 1:256).
- R5: Every wrap from 255 to 0 sets the flag. The flag stays set until a write of bit0=0 to address 2.
- R6: If a flag-clear write and a wrap fall in the same cycle, the flag ends up set.
- R7: With source=1, the counter counts edges of `ext_in` after a two-flop synchronizer: rising edges when edge select=0, falling edges when edge select=1. `cyc_tick` then has no effect on the count.
- R8: With assignment=1, `wdt_tick` pulses for one cycle once every 2^(k+1) `cyc_tick` events, counted from the last counter write. With assignment=0, it never pulses.
- R9: A counter write in a cycle that also carries an increment loads the written value, and no increment or wrap occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | Instruction-cycle enable, one pulse per cycle event |
| ext_in | input | 1 | External count input, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| wdt_tick | output | 1 | Prescaled tick toward the watchdog path |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a counter wrap and a software flag clear. The second is a counter write and a prescaled increment. Directed cases line these up on purpose: the counter is loaded with 0xFF, and the next cycle carries both a tick and a flag-clear write, or both a tick and a counter write. The bench then judges the outcome against the stated priority: the flag stays set, and the written value replaces the increment. Random bus traffic mixed with ticks revisits both collisions, and every cycle is compared against a bench model.

// File: rtl/tt_pkg.sv
package tt_pkg;
    localparam int DW     = 8;
    localparam int PRE_W  = 8;
    localparam int RATE_W = $clog2(PRE_W);
    localparam int AW     = 2;

    localparam logic [AW-1:0] A_TMR = 2'd0;
    localparam logic [AW-1:0] A_CFG = 2'd1;
    localparam logic [AW-1:0] A_FLG = 2'd2;

    typedef struct packed {
        logic [DW-RATE_W-4:0] spare;
        logic                 src;
        logic                 asg;
        logic                 edge_fall;
        logic [RATE_W-1:0]    rate;
    } cfg_t;
endpackage

// File: rtl/tt_sync_edge.sv
module tt_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic fall_sel,
    output logic pulse
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sy_t;

    sy_t sy_q, sy_d;

    always_comb begin
        sy_d.s1 = din;
        sy_d.s2 = sy_q.s1;
        sy_d.s3 = sy_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign pulse = fall_sel ? (sy_q.s3 & ~sy_q.s2) : (sy_q.s2 & ~sy_q.s3);
endmodule

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
    parameter int PW = 8,
    parameter int SW = $clog2(PW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic [SW-1:0] sel,
    output logic          term
);
    logic [PW-1:0] cnt_q, cnt_d;
    logic [PW-1:0] mask;

    // Bits at or below the selected tap take part in terminal detection.
    for (genvar i = 0; i < PW; i++) begin : g_mask
        assign mask[i] = ({1'b0, sel} >= (SW+1)'(i));
    end

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (adv) cnt_d = cnt_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // High when the next advance carries out of the selected tap.
    assign term = &(cnt_q | ~mask);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_tick,
    input  logic          ext_in,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          wdt_tick
);
    typedef struct packed {
        logic [DW-1:0] tmr;
        logic          flag;
        cfg_t          cfg;
        logic          wdt;
    } st_t;

    st_t st_q, st_d;

    logic          ext_pulse, src_tick, pre_adv, term, inc, ovf;
    logic          wr_tmr, wr_cfg, wr_flg;
    logic [DW-1:0] tmr_q;
    logic          flag_q, asg_q;

    assign tmr_q  = st_q.tmr;
    assign flag_q = st_q.flag;
    assign asg_q  = st_q.cfg.asg;

    assign wr_tmr = wr_en && (addr == A_TMR);
    assign wr_cfg = wr_en && (addr == A_CFG);
    assign wr_flg = wr_en && (addr == A_FLG);

    tt_sync_edge u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (ext_in),
        .fall_sel (st_q.cfg.edge_fall),
        .pulse    (ext_pulse)
    );

    assign src_tick = st_q.cfg.src ? ext_pulse : cyc_tick;
    assign pre_adv  = st_q.cfg.asg ? cyc_tick : src_tick;
    assign inc      = st_q.cfg.asg ? src_tick : (src_tick & term);
    assign ovf      = inc && !wr_tmr && (st_q.tmr == {DW{1'b1}});

    tt_prescaler #(.PW(PRE_W), .SW(RATE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_tmr),
        .adv   (pre_adv),
        .sel   (st_q.cfg.rate),
        .term  (term)
    );

    always_comb begin
        st_d = st_q;
        if (wr_tmr)   st_d.tmr = wdata;
        else if (inc) st_d.tmr = st_q.tmr + DW'(1);
        if (wr_cfg)   st_d.cfg = cfg_t'(wdata);
        if (wr_flg)   st_d.flag = ovf | wdata[0];
        else          st_d.flag = ovf | st_q.flag;
        st_d.wdt = st_q.cfg.asg & cyc_tick & term;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{tmr: '0, flag: 1'b0, cfg: cfg_t'('1), wdt: 1'b0};
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr)
            A_TMR:   rdata = st_q.tmr;
            A_CFG:   rdata = st_q.cfg;
            A_FLG:   rdata = {{(DW-1){1'b0}}, st_q.flag};
            default: rdata = '0;
        endcase
    end

    assign wdt_tick = st_q.wdt;
endmodule

// File: rtl/tt_chk.sv
module tt_chk
    import tt_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] tmr_q,
    input logic          flag_q,
    input logic          ovf,
    input logic          asg_q,
    input logic          wdt_tick
);
    // R2
    tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_TMR) |=> (tmr_q == $past(wdata)));

    // R3
    tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_TMR) |=>
            (tmr_q == $past(tmr_q) || tmr_q == $past(tmr_q) + DW'(1)));

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_en && addr == A_FLG && !wdata[0])) |=> flag_q);

    // R6
    ovf_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> flag_q);

    // R8
    wdt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !asg_q |=> !wdt_tick);
endmodule

bind tick_timer tt_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .tmr_q    (tmr_q),
    .flag_q   (flag_q),
    .ovf      (ovf),
    .asg_q    (asg_q),
    .wdt_tick (wdt_tick)
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
    import tt_pkg::*;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_tick = 1'b0;
    logic          ext_in = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          wdt_tick;

    int vecs = 0;
    int miss = 0;
    bit done = 0;

    logic [7:0] m_tmr, m_cfg, m_pre;
    logic       m_flag, m_wdt;

    tick_timer u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_in(ext_in),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .wdt_tick(wdt_tick)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vecs++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_tmr;
            2'd1:    return m_cfg;
            2'd2:    return {7'b0, m_flag};
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_reset();
        m_tmr = 8'h00; m_cfg = 8'hFF; m_pre = 8'h00; m_flag = 1'b0; m_wdt = 1'b0;
    endtask

    // Next state from R3, R4, R5, R6, R8, R9 (internal source only).
    task automatic m_update(input bit w, input logic [1:0] a, input logic [7:0] d, input bit t);
        logic       asg, src, st, adv, inc, full, ovf;
        logic [7:0] mask;
        asg  = m_cfg[4];
        src  = m_cfg[5];
        mask = 8'((9'd2 << m_cfg[2:0]) - 9'd1);
        full = ((m_pre | ~mask) == 8'hFF);
        st   = src ? 1'b0 : t;
        adv  = asg ? t : st;
        inc  = asg ? st : (st & full);
        ovf  = inc && !(w && a == 2'd0) && (m_tmr == 8'hFF);
        m_wdt = asg & t & full;
        if (w && a == 2'd0) begin
            m_tmr = d; m_pre = 8'h00;
        end else begin
            if (inc) m_tmr = m_tmr + 8'd1;
            if (adv) m_pre = m_pre + 8'd1;
        end
        if (w && a == 2'd1) m_cfg = d;
        if (w && a == 2'd2) m_flag = ovf | d[0];
        else                m_flag = ovf | m_flag;
    endtask

    task automatic step(input bit w, input logic [1:0] a, input logic [7:0] d,
                        input bit t, input bit mdl, input string tag);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; cyc_tick = t;
        @(posedge clk);
        if (mdl) m_update(w, a, d, t);
        #1;
        if (mdl) begin
            chk(tag, rdata, m_read(a));
            chk({tag, " R8 wdt"}, {7'b0, wdt_tick}, {7'b0, m_wdt});
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; cyc_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_reset();
    endtask

    task automatic ext_pulses(input int n);
        for (int p = 0; p < n; p++) begin
            ext_in = 1'b1;
            for (int c = 0; c < 4; c++) step(0, 2'd0, 8'h00, 1'($urandom), 0, "R7");
            ext_in = 1'b0;
            for (int c = 0; c < 4; c++) step(0, 2'd0, 8'h00, 1'($urandom), 0, "R7");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miss++;
            vecs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
            $finish;
        end
    end

    initial begin
        int pulses;
        void'($urandom(32'd1234));
        m_reset();
        do_reset();

        // R1 reset values
        step(0, 2'd0, 8'h00, 0, 1, "R1"); chk("R1 tmr", rdata, 8'h00);
        step(0, 2'd1, 8'h00, 0, 1, "R1"); chk("R1 cfg", rdata, 8'hFF);
        step(0, 2'd2, 8'h00, 0, 1, "R1"); chk("R1 flag", rdata, 8'h00);

        // R7 counter mode, rising edges
        step(1, 2'd1, 8'h30, 0, 0, "R7");
        step(1, 2'd0, 8'h00, 0, 0, "R7");
        ext_pulses(5);
        chk("R7 rising", rdata, 8'h05);
        // R7 falling edges
        step(1, 2'd1, 8'h38, 0, 0, "R7");
        step(1, 2'd0, 8'h00, 0, 0, "R7");
        ext_pulses(3);
        step(0, 2'd0, 8'h00, 1, 0, "R7");
        chk("R7 falling", rdata, 8'h03);

        do_reset();
        // R2 readback
        step(1, 2'd1, 8'h13, 0, 1, "R2"); chk("R2 cfg", rdata, 8'h13);
        step(1, 2'd0, 8'hFE, 0, 1, "R2"); chk("R2 tmr", rdata, 8'hFE);
        // R3 direct count and wrap, R5 flag
        step(0, 2'd0, 8'h00, 1, 1, "R3"); chk("R3 step", rdata, 8'hFF);
        step(0, 2'd0, 8'h00, 1, 1, "R3"); chk("R3 wrap", rdata, 8'h00);
        step(0, 2'd2, 8'h00, 0, 1, "R5"); chk("R5 set", rdata, 8'h01);
        step(0, 2'd2, 8'h00, 1, 1, "R5"); chk("R5 sticky", rdata, 8'h01);
        step(1, 2'd2, 8'h00, 0, 1, "R5"); chk("R5 clear", rdata, 8'h00);
        // R6 overflow beats clear
        step(1, 2'd0, 8'hFF, 0, 1, "R6");
        step(1, 2'd2, 8'h00, 1, 1, "R6"); chk("R6 ovf wins", rdata, 8'h01);
        // R9 write beats increment
        step(1, 2'd0, 8'hFF, 0, 1, "R9");
        step(1, 2'd2, 8'h00, 0, 1, "R9");
        step(1, 2'd0, 8'h40, 1, 1, "R9"); chk("R9 load", rdata, 8'h40);
        step(0, 2'd2, 8'h00, 0, 1, "R9"); chk("R9 no wrap", rdata, 8'h00);

        // R4 prescaled 1:8
        step(1, 2'd1, 8'h02, 0, 1, "R4");
        step(1, 2'd0, 8'h10, 0, 1, "R4");
        for (int i = 0; i < 7; i++) step(0, 2'd0, 8'h00, 1, 1, "R4");
        chk("R4 before", rdata, 8'h10);
        step(0, 2'd0, 8'h00, 1, 1, "R4"); chk("R4 first", rdata, 8'h11);
        for (int i = 0; i < 8; i++) step(0, 2'd0, 8'h00, 1, 1, "R4");
        chk("R4 second", rdata, 8'h12);

        // R8 watchdog tick 1:4 when assigned, silent otherwise
        step(1, 2'd1, 8'h11, 0, 1, "R8");
        step(1, 2'd0, 8'h00, 0, 1, "R8");
        pulses = 0;
        for (int i = 0; i < 16; i++) begin
            step(0, 2'd0, 8'h00, 1, 1, "R8");
            pulses += int'(wdt_tick);
        end
        chk("R8 assigned", 8'(pulses), 8'd4);
        step(1, 2'd1, 8'h01, 0, 1, "R8");
        pulses = 0;
        for (int i = 0; i < 16; i++) begin
            step(0, 2'd0, 8'h00, 1, 1, "R8");
            pulses += int'(wdt_tick);
        end
        chk("R8 unassigned", 8'(pulses), 8'd0);

        // Random traffic against the model (R3 R4 R5 R6 R8 R9)
        for (int i = 0; i < 4000; i++) begin
            bit         w;
            logic [1:0] a;
            logic [7:0] d;
            w = (($urandom % 8) == 0);
            a = 2'($urandom % 3);
            d = 8'($urandom);
            if (a == 2'd1 && ($urandom % 2) == 0) d[2:0] = 3'($urandom % 3);
            step(w, a, d, (($urandom % 4) != 0), 1, "R4 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end
endmodule